// File: doc/BRIEF.md
# Register-mapped serial port core

This block is an asynchronous serial port controlled through a small word-addressed register window on a simple 32-bit bus. Software writes characters into a 16-entry transmit queue and reads received characters, each with its own error flags, out of a 16-entry receive queue. The serializer and deserializer advance on an externally generated oversampling tick, so the baud rate is set outside this block.

Word length of 5 to 8 bits, optional even or odd parity, one or two stop bits and a forced-low break condition are set by the line register. Four interrupt causes are latched into an identification register: receive fill level, transmit drain level, receive idle timeout and a change on the clear-to-send input. Software clears them by writing that register, and they drive one interrupt output.

Top module: `uart_core`

## Requirements
- R1: After reset, line = 0x00, control = 0x00, rx level = 1, tx level = 0, identification = 0, irq_o = 0, txd_o = 1. Flags read 0x90 with cts_i low. Line (0x08), control (0x14), rx level (0x38) and tx level (0x3C) read back what was written.
- R2: With control bit0 set, a queued character leaves on txd_o as one low start bit, then the data bits LSB first, then the parity bit if line bit1 is set, then the stop bits, high. The data bit count is 5 + line[6:5]. Parity is even when line bit2 is 1 and odd when it is 0. Line bit3 selects two stop bits. Each bit lasts OVS ticks.
- R3: A frame received on rxd_i in the same format is queued. A read of offset 0x00 returns its data bits in [7:0] and removes it from the queue.
- R4: The receive status register (0x04) shows bit0 framing error (stop bit low), bit1 parity error and bit2 break (all data, parity and stop bits low; it also sets bit0). These bits belong to the character most recently read. Any write to 0x04 clears the register.
- R5: A character that completes while the receive queue is full is dropped, and status bit3 (overrun) is set until 0x04 is written.
- R6: Line bit0 holds txd_o low while it is set.
- R7: Flags (0x18) read bit0 synchronized cts_i, bit3 busy, bit4 rx empty, bit5 tx full, bit6 rx full and bit7 tx empty.
- R8: Busy is set while the transmit queue holds data or a frame is on the line, up to the end of the last stop bit.
- R9: With line bit4 (queue enable) clear, each queue holds one character. A data write to a full transmit queue is dropped.
- R10: Identification bits 0 to 3 latch, in that order, a clear-to-send change, the receive level, the transmit level and the receive timeout, each only while its control bit (3, 4, 5, 6) is set. irq_o is high while any bit is set. A write to 0x1C clears the bits, and any cause still active is raised again in the same cycle.
- R11: The transmit cause is active while the transmit fill count is at most the tx level. The receive cause is active while the receive queue is non-empty and its count is at least the rx level.
- R12: The timeout cause is raised once the receive queue has been non-empty with no new character for TOUT_BITS bit times (TOUT_BITS*OVS ticks), and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oversampling tick, OVS per bit time |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | Access is a write |
| addr_i | input | 6 | Byte address within the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| cts_i | input | 1 | Clear-to-send input |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong bit counter or a wrong parity sense in the serializer shows as a wrong level on txd_o within one frame, and as a mismatched character or a spurious error flag as soon as that frame is read back. A queue count that drifts shows at once as a wrong empty or full flag, or as the receive interrupt firing at the wrong fill level. A timeout counter that restarts wrongly shows as a timeout bit raised early or late against the 32-bit-time window. A lost synchronizer edge shows as a missing clear-to-send cause within a few cycles of the input change.

// File: rtl/uart_core_pkg.sv
package uart_core_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ERR_W  = 3;  // {break, parity, framing}

  localparam logic [3:0] A_DATA = 4'h0;
  localparam logic [3:0] A_STAT = 4'h1;
  localparam logic [3:0] A_LINE = 4'h2;
  localparam logic [3:0] A_CTRL = 4'h5;
  localparam logic [3:0] A_FLAG = 4'h6;
  localparam logic [3:0] A_IID  = 4'h7;
  localparam logic [3:0] A_RXLV = 4'hE;
  localparam logic [3:0] A_TXLV = 4'hF;

  typedef struct packed {
    logic       stp2;
    logic       eps;
    logic       pen;
    logic [1:0] wl;
  } frame_cfg_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
  } rx_state_e;

  function automatic logic [3:0] data_len(logic [1:0] wl);
    return 4'd5 + {2'b00, wl};
  endfunction
endpackage

// File: rtl/uart_fifo.sv
// DEPTH must be a power of two; pointers wrap naturally.
module uart_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [$clog2(DEPTH):0]     lim_i,
  input  logic                       push_i,
  input  logic [W-1:0]               data_i,
  input  logic                       pop_i,
  output logic [W-1:0]               data_o,
  output logic [$clog2(DEPTH):0]     cnt_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full_o  = cnt_q >= lim_i;
  assign empty_o = cnt_q == '0;
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign data_o  = mem_q[rd_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser import uart_core_pkg::*; #(
  parameter int unsigned OVS = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               en_i,
  input  frame_cfg_t         cfg_i,
  input  logic               valid_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic               pop_o,
  output logic               txd_o,
  output logic               active_o
);
  localparam int unsigned OW = $clog2(OVS);

  logic [11:0]       sh_q, frm;
  logic [3:0]        left_q, flen, nd;
  logic [OW-1:0]     ov_q;
  logic [DATA_W-1:0] dm;
  logic              par;

  always_comb begin
    nd   = data_len(cfg_i.wl);
    dm   = data_i & (8'hFF >> (4'd8 - nd));
    par  = ^dm ^ ~cfg_i.eps;
    frm  = '1;
    frm[0] = 1'b0;
    for (int i = 0; i < 8; i++) if (i < int'(nd)) frm[i+1] = dm[i];
    if (cfg_i.pen) frm[nd + 4'd1] = par;
    flen = nd + 4'd2 + {3'b000, cfg_i.pen} + {3'b000, cfg_i.stp2};
  end

  assign active_o = left_q != '0;
  assign pop_o    = ~active_o & valid_i & en_i;
  assign txd_o    = active_o ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      ov_q   <= '0;
    end else if (pop_o) begin
      sh_q   <= frm;
      left_q <= flen;
      ov_q   <= '0;
    end else if (active_o && tick_i) begin
      if (ov_q == OW'(OVS - 1)) begin
        ov_q   <= '0;
        sh_q   <= {1'b1, sh_q[11:1]};
        left_q <= left_q - 4'd1;
      end else begin
        ov_q <= ov_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx_des.sv
module uart_rx_des import uart_core_pkg::*; #(
  parameter int unsigned OVS = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               en_i,
  input  logic [1:0]         wl_i,
  input  logic               pen_i,
  input  logic               eps_i,
  input  logic               rxd_i,
  output logic               push_o,
  output logic [DATA_W-1:0]  data_o,
  output logic [ERR_W-1:0]   err_o
);
  localparam int unsigned OW = $clog2(OVS);

  rx_state_e         st_q;
  logic [OW-1:0]     ov_q;
  logic [2:0]        idx_q;
  logic [DATA_W-1:0] dat_q;
  logic              pb_q;
  logic [3:0]        nd;
  logic              at_mid, at_end;

  assign nd     = data_len(wl_i);
  assign at_mid = ov_q == OW'(OVS / 2 - 1);
  assign at_end = ov_q == OW'(OVS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      ov_q   <= '0;
      idx_q  <= '0;
      dat_q  <= '0;
      pb_q   <= 1'b0;
      push_o <= 1'b0;
      data_o <= '0;
      err_o  <= '0;
    end else begin
      push_o <= 1'b0;
      unique case (st_q)
        RX_IDLE: begin
          ov_q <= '0;
          if (en_i && !rxd_i) st_q <= RX_START;
        end
        RX_START: if (tick_i) begin
          if (at_mid) begin
            ov_q  <= '0;
            idx_q <= '0;
            dat_q <= '0;
            st_q  <= rxd_i ? RX_IDLE : RX_DATA;
          end else ov_q <= ov_q + 1'b1;
        end
        RX_DATA: if (tick_i) begin
          if (at_end) begin
            ov_q         <= '0;
            dat_q[idx_q] <= rxd_i;
            idx_q        <= idx_q + 3'd1;
            if ({1'b0, idx_q} == nd - 4'd1) st_q <= pen_i ? RX_PAR : RX_STOP;
          end else ov_q <= ov_q + 1'b1;
        end
        RX_PAR: if (tick_i) begin
          if (at_end) begin
            ov_q <= '0;
            pb_q <= rxd_i;
            st_q <= RX_STOP;
          end else ov_q <= ov_q + 1'b1;
        end
        RX_STOP: if (tick_i) begin
          if (at_end) begin
            ov_q     <= '0;
            push_o   <= 1'b1;
            data_o   <= dat_q;
            err_o[0] <= ~rxd_i;
            err_o[1] <= pen_i & (pb_q != (^dat_q ^ ~eps_i));
            err_o[2] <= ~rxd_i & (dat_q == '0) & (~pen_i | ~pb_q);
            st_q     <= rxd_i ? RX_IDLE : RX_HOLD;
          end else ov_q <= ov_q + 1'b1;
        end
        RX_HOLD: if (rxd_i) st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_core.sv
module uart_core import uart_core_pkg::*; #(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned OVS        = 16,
  parameter int unsigned TOUT_BITS  = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [5:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        rxd_i,
  output logic        txd_o,
  input  logic        cts_i,
  output logic        irq_o
);
  localparam int unsigned CW       = $clog2(FIFO_DEPTH) + 1;
  localparam int unsigned RXW      = DATA_W + ERR_W;
  localparam int unsigned TOUT_LIM = TOUT_BITS * OVS;
  localparam int unsigned TW       = $clog2(TOUT_LIM + 1);

  logic [3:0]  widx;
  logic        wr, rd;
  logic        wr_data, wr_stat, wr_line, wr_ctrl, wr_iid, wr_rxlv, wr_txlv, rd_data;
  logic [6:0]  lcr_q, cr_q;
  logic [CW-1:0] rxl_q, txl_q, lim;
  logic [3:0]  st_q, iir_q, set;
  logic [1:0]  cts_s, rxd_s;
  logic        cts_d, cts_chg;
  frame_cfg_t  cfg;

  logic              tx_pop, tx_full, tx_empty, tx_active, ser_txd;
  logic [DATA_W-1:0] tx_head;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              rx_push, rx_full, rx_empty, rx_pop, ovr_evt;
  logic [DATA_W-1:0] rx_data;
  logic [ERR_W-1:0]  rx_err;
  logic [RXW-1:0]    rx_head;
  logic              busy, tout_hit;
  logic [TW-1:0]     tcnt_q;
  logic [7:0]        flags;
  logic              unused_bits;

  assign unused_bits = ^{addr_i[1:0], wdata_i[31:8]};

  assign widx    = addr_i[5:2];
  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign wr_data = wr & (widx == A_DATA);
  assign wr_stat = wr & (widx == A_STAT);
  assign wr_line = wr & (widx == A_LINE);
  assign wr_ctrl = wr & (widx == A_CTRL);
  assign wr_iid  = wr & (widx == A_IID);
  assign wr_rxlv = wr & (widx == A_RXLV);
  assign wr_txlv = wr & (widx == A_TXLV);
  assign rd_data = rd & (widx == A_DATA);

  assign cfg = '{stp2: lcr_q[3], eps: lcr_q[2], pen: lcr_q[1], wl: lcr_q[6:5]};
  assign lim = lcr_q[4] ? CW'(FIFO_DEPTH) : CW'(1);

  uart_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk_i, .rst_ni, .lim_i(lim),
    .push_i(wr_data), .data_i(wdata_i[DATA_W-1:0]), .pop_i(tx_pop),
    .data_o(tx_head), .cnt_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
  );

  uart_tx_ser #(.OVS(OVS)) tx_i (
    .clk_i, .rst_ni, .tick_i, .en_i(cr_q[0]), .cfg_i(cfg),
    .valid_i(~tx_empty), .data_i(tx_head),
    .pop_o(tx_pop), .txd_o(ser_txd), .active_o(tx_active)
  );

  uart_rx_des #(.OVS(OVS)) rx_i (
    .clk_i, .rst_ni, .tick_i, .en_i(cr_q[0]),
    .wl_i(cfg.wl), .pen_i(cfg.pen), .eps_i(cfg.eps), .rxd_i(rxd_s[1]),
    .push_o(rx_push), .data_o(rx_data), .err_o(rx_err)
  );

  assign rx_pop  = rd_data & ~rx_empty;
  assign ovr_evt = rx_push & rx_full;

  uart_fifo #(.W(RXW), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk_i, .rst_ni, .lim_i(lim),
    .push_i(rx_push), .data_i({rx_err, rx_data}), .pop_i(rd_data),
    .data_o(rx_head), .cnt_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  assign txd_o = ser_txd & ~lcr_q[0];
  assign busy  = ~tx_empty | tx_active;
  assign flags = {tx_empty, rx_full, tx_full, rx_empty, busy, 2'b00, cts_s[1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cts_s <= '0;
      cts_d <= 1'b0;
      rxd_s <= '1;
    end else begin
      cts_s <= {cts_s[0], cts_i};
      cts_d <= cts_s[1];
      rxd_s <= {rxd_s[0], rxd_i};
    end
  end
  assign cts_chg = cts_s[1] ^ cts_d;

  // idle time counter, restarted by each arrival
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         tcnt_q <= '0;
    else if (rx_empty || rx_push)        tcnt_q <= '0;
    else if (tick_i && tcnt_q < TW'(TOUT_LIM)) tcnt_q <= tcnt_q + 1'b1;
  end
  assign tout_hit = tick_i & ~rx_empty & ~rx_push & (tcnt_q == TW'(TOUT_LIM - 1));

  assign set[0] = cr_q[3] & cts_chg;
  assign set[1] = cr_q[4] & ~rx_empty & (rx_cnt >= rxl_q);
  assign set[2] = cr_q[5] & (tx_cnt <= txl_q);
  assign set[3] = cr_q[6] & tout_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q <= '0;
      cr_q  <= '0;
      rxl_q <= CW'(1);
      txl_q <= '0;
      st_q  <= '0;
      iir_q <= '0;
    end else begin
      if (wr_line) lcr_q <= wdata_i[6:0];
      if (wr_ctrl) cr_q  <= wdata_i[6:0];
      if (wr_rxlv) rxl_q <= wdata_i[CW-1:0];
      if (wr_txlv) txl_q <= wdata_i[CW-1:0];
      iir_q <= (wr_iid ? 4'b0 : iir_q) | set;
      if (wr_stat)     st_q      <= '0;
      else if (rx_pop) st_q[2:0] <= rx_head[RXW-1:DATA_W];
      if (ovr_evt)     st_q[3]   <= 1'b1;
    end
  end

  assign irq_o = |iir_q;

  always_comb begin
    unique case (widx)
      A_DATA:  rdata_o = {24'b0, rx_head[DATA_W-1:0]};
      A_STAT:  rdata_o = {28'b0, st_q};
      A_LINE:  rdata_o = {25'b0, lcr_q};
      A_CTRL:  rdata_o = {25'b0, cr_q};
      A_FLAG:  rdata_o = {24'b0, flags};
      A_IID:   rdata_o = {28'b0, iir_q};
      A_RXLV:  rdata_o = 32'(rxl_q);
      A_TXLV:  rdata_o = 32'(txl_q);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/uart_core_chk.sv
module uart_core_chk #(
  parameter int unsigned FIFO_DEPTH = 16
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         txd_i,
  input logic                         brk_i,
  input logic                         busy_i,
  input logic [$clog2(FIFO_DEPTH):0]  tx_cnt_i,
  input logic [$clog2(FIFO_DEPTH):0]  rx_cnt_i,
  input logic                         wr_stat_i,
  input logic                         ovr_i,
  input logic [3:0]                   st_i,
  input logic [3:0]                   iir_i
);
  localparam int unsigned CW = $clog2(FIFO_DEPTH) + 1;

  // R8
  idle_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !brk_i) |-> txd_i);

  // R9
  tx_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt_i <= CW'(FIFO_DEPTH));

  // R3
  rx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt_i <= $past(rx_cnt_i) + CW'(1));

  // R4
  stat_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat_i && !ovr_i) |=> (st_i == 4'b0));

  // R12
  tout_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iir_i[3]) |-> ($past(rx_cnt_i) != '0));
endmodule

bind uart_core uart_core_chk #(.FIFO_DEPTH(FIFO_DEPTH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .txd_i(txd_o), .brk_i(lcr_q[0]),
  .busy_i(busy), .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt),
  .wr_stat_i(wr_stat), .ovr_i(ovr_evt), .st_i(st_q), .iir_i(iir_q)
);

// File: tb/uart_core_tb_top.sv
module uart_core_tb_top;
  localparam int A_DATA = 'h00, A_STAT = 'h04, A_LINE = 'h08, A_CTRL = 'h14;
  localparam int A_FLAG = 'h18, A_IID = 'h1C, A_RXLV = 'h38, A_TXLV = 'h3C;
  localparam int BIT = 16;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        txd, irq, cts = 1'b0, loop_en = 1'b1, drv_rxd = 1'b1;
  logic        rxd;
  int          n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;
  assign rxd = loop_en ? txd : drv_rxd;

  uart_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(1'b1), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd),
    .txd_o(txd), .cts_i(cts), .irq_o(irq)
  );

  task automatic chk(string req_s, int act, int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req_s, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = 6'(a); wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = 6'(a);
    #1 d = int'(rdata);
    @(negedge clk); req = 1'b0;
  endtask

  function automatic int mask(int d, int wl);
    return d & ((1 << (5 + wl)) - 1);
  endfunction

  function automatic int par_bit(int d, int eps);
    return ($countones(d) & 1) ^ (eps ? 0 : 1);
  endfunction

  function automatic logic [11:0] exp_frame(int d, int wl, int pen, int eps);
    logic [11:0] f = '1;
    int nd = 5 + wl;
    int dm = mask(d, wl);
    f[0] = 1'b0;
    for (int i = 0; i < nd; i++) f[i+1] = dm[i];
    if (pen != 0) f[nd+1] = 1'(par_bit(dm, eps));
    return f;
  endfunction

  task automatic mon_frame(int len, output logic [11:0] bits);
    bits = '1;
    while (txd !== 1'b0) @(negedge clk);
    repeat (BIT / 2) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      bits[i] = txd;
      if (i < len - 1) repeat (BIT) @(negedge clk);
    end
  endtask

  task automatic drive_frame(int d, int nd, int pen, int pb, int stopv);
    @(negedge clk); drv_rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < nd; i++) begin
      drv_rxd = d[i]; repeat (BIT) @(negedge clk);
    end
    if (pen != 0) begin drv_rxd = 1'(pb); repeat (BIT) @(negedge clk); end
    drv_rxd = 1'(stopv); repeat (BIT) @(negedge clk);
    drv_rxd = 1'b1; repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic wait_rx();
    int f;
    for (int k = 0; k < 2000; k++) begin
      rd(A_FLAG, f);
      if ((f & 'h10) == 0) break;
    end
  endtask

  task automatic wait_tx_idle();
    int f;
    for (int k = 0; k < 2000; k++) begin
      rd(A_FLAG, f);
      if ((f & 'h08) == 0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int v, seed;
    logic [11:0] bits;
    seed = $urandom(32'd1207);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 txd idle", int'(txd), 1);
    chk("R1 irq", int'(irq), 0);
    rd(A_FLAG, v); chk("R1 R7 flags", v, 'h90);
    rd(A_LINE, v); chk("R1 line", v, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_RXLV, v); chk("R1 rx level", v, 1);
    rd(A_TXLV, v); chk("R1 tx level", v, 0);
    rd(A_IID, v);  chk("R1 iid", v, 0);
    wr(A_TXLV, 5); rd(A_TXLV, v); chk("R1 tx level readback", v, 5);
    wr(A_TXLV, 0);

    // R2 directed frames: 8 data even parity, then 5 data odd parity two stops
    wr(A_LINE, 'h76); wr(A_CTRL, 1); wr(A_DATA, 'hA5);
    mon_frame(11, bits);
    chk("R2 frame 8E1", int'(bits[10:0]), int'(exp_frame('hA5, 3, 1, 1) & 12'h7FF));
    wait_rx(); rd(A_DATA, v); chk("R3 loop 8E1", v, 'hA5);
    rd(A_STAT, v); chk("R4 clean status", v, 0);
    wr(A_LINE, 'h1A); wr(A_DATA, 'hF3);
    mon_frame(9, bits);
    chk("R2 frame 5O2", int'(bits[8:0]), int'(exp_frame('hF3, 0, 1, 0) & 12'h1FF));
    rd(A_FLAG, v); chk("R8 busy in last stop", (v >> 3) & 1, 1);
    repeat (12) @(negedge clk);
    rd(A_FLAG, v); chk("R8 busy after stop", (v >> 3) & 1, 0);
    rd(A_DATA, v); chk("R3 loop 5O2", v, mask('hF3, 0));

    // R3 random configurations through the loop
    for (int k = 0; k < 30; k++) begin
      int wl = int'($urandom % 4), pen = int'($urandom % 2);
      int eps = int'($urandom % 2), stp = int'($urandom % 2), d = int'($urandom % 256);
      wr(A_LINE, 'h10 | (wl << 5) | (stp << 3) | (eps << 2) | (pen << 1));
      wr(A_DATA, d);
      wait_rx();
      rd(A_DATA, v); chk("R3 random data", v, mask(d, wl));
      rd(A_STAT, v); chk("R4 random status", v, 0);
    end
    wait_tx_idle();

    // R4 injected errors
    loop_en = 1'b0;
    wr(A_LINE, 'h76);
    drive_frame('h5A, 8, 1, par_bit('h5A, 1) ^ 1, 1);
    rd(A_DATA, v); chk("R4 parity data", v, 'h5A);
    rd(A_STAT, v); chk("R4 parity flag", v, 'h2);
    wr(A_STAT, 0); rd(A_STAT, v); chk("R4 status write clears", v, 0);
    wr(A_LINE, 'h70);
    drive_frame('h33, 8, 0, 0, 0);
    rd(A_DATA, v); chk("R4 framing data", v, 'h33);
    rd(A_STAT, v); chk("R4 framing flag", v, 'h1);
    drive_frame('h00, 8, 0, 0, 0);
    rd(A_DATA, v); chk("R4 break data", v, 0);
    rd(A_STAT, v); chk("R4 break flags", v, 'h5);

    // R5 R9 single-entry queues and overrun
    wr(A_STAT, 0); wr(A_LINE, 'h60);
    drive_frame('h11, 8, 0, 0, 1);
    rd(A_FLAG, v); chk("R9 R7 rx full at one", v & 'h50, 'h40);
    drive_frame('h22, 8, 0, 0, 1);
    rd(A_DATA, v); chk("R5 first kept", v, 'h11);
    rd(A_STAT, v); chk("R5 overrun flag", v, 'h8);
    rd(A_FLAG, v); chk("R5 second dropped", (v >> 4) & 1, 1);
    wr(A_STAT, 0); rd(A_STAT, v); chk("R5 overrun cleared", v, 0);
    wr(A_CTRL, 0); wr(A_DATA, 'h55); wr(A_DATA, 'h66);
    rd(A_FLAG, v); chk("R9 R7 tx full at one", v & 'hA0, 'h20);
    loop_en = 1'b1; wr(A_CTRL, 1);
    wait_rx(); rd(A_DATA, v); chk("R9 tx kept first", v, 'h55);
    repeat (400) @(negedge clk);
    rd(A_FLAG, v); chk("R9 tx second dropped", v & 'h90, 'h90);

    // R6 break
    loop_en = 1'b0; wr(A_LINE, 'h71);
    repeat (5) @(negedge clk); chk("R6 break low", int'(txd), 0);
    repeat (50) @(negedge clk); chk("R6 break held", int'(txd), 0);
    wr(A_LINE, 'h70); @(negedge clk); chk("R6 break released", int'(txd), 1);
    loop_en = 1'b1;

    // R10 R11 receive level
    wr(A_RXLV, 3); wr(A_CTRL, 'h11); wr(A_IID, 0);
    wr(A_DATA, 'h01); wr(A_DATA, 'h02); wait_tx_idle();
    rd(A_IID, v); chk("R11 below rx level", v, 0);
    chk("R10 irq low", int'(irq), 0);
    wr(A_DATA, 'h03); wait_tx_idle();
    rd(A_IID, v); chk("R11 rx level reached", v, 'h2);
    chk("R10 irq high", int'(irq), 1);
    wr(A_IID, 0); rd(A_IID, v); chk("R10 cause re-raised", v, 'h2);
    for (int k = 1; k <= 3; k++) begin rd(A_DATA, v); chk("R3 queued order", v, k); end
    wr(A_IID, 0); rd(A_IID, v); chk("R10 cleared", v, 0);
    chk("R10 irq cleared", int'(irq), 0);

    // R11 transmit level
    wr(A_CTRL, 'h21); @(negedge clk);
    rd(A_IID, v); chk("R11 tx level cause", v, 'h4);
    wr(A_CTRL, 1); wr(A_IID, 0); rd(A_IID, v); chk("R10 tx cleared", v, 0);

    // R12 receive timeout
    wr(A_RXLV, 1); wr(A_CTRL, 'h41); wr(A_DATA, 'h7E);
    wait_rx();
    repeat (400) @(negedge clk);
    rd(A_IID, v); chk("R12 not early", v, 0);
    repeat (150) @(negedge clk);
    rd(A_IID, v); chk("R12 timeout raised", v, 'h8);
    rd(A_DATA, v); chk("R12 data", v, 'h7E);
    wr(A_IID, 0); rd(A_IID, v); chk("R12 cleared", v, 0);

    // R10 R7 clear-to-send change
    wr(A_CTRL, 'h09); wr(A_IID, 0);
    cts = 1'b1; repeat (5) @(negedge clk);
    rd(A_IID, v); chk("R10 cts rise cause", v, 'h1);
    rd(A_FLAG, v); chk("R7 cts flag", v & 1, 1);
    wr(A_IID, 0); rd(A_IID, v); chk("R10 cts steady", v, 0);
    cts = 1'b0; repeat (5) @(negedge clk);
    rd(A_IID, v); chk("R10 cts fall cause", v, 'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule